// File: doc/BRIEF.md
# Arpeggio Clock Start/Stop Gate

This block decides when a free-running arpeggio tick may reach the processor's interrupt input. A phase counter on the system clock produces the raw arpeggio square wave. That wave always drives the clock-out pin, whatever the mode. The interrupt output carries the same wave halved, and only while an internal start latch is set.

Start is set by a key press, but only when the keyboard mode is arpeggio or split. The cycle in which start is set also restarts the oscillator phase and clears the halving flip-flop. Because of this, the first interrupt tick always comes a fixed number of cycles after the press. Releasing every key clears start, unless the hold switch is on or the pedal circuit is open; in that case start stays set. Leaving arpeggio or split mode clears start in every case.

The asynchronous key, hold and pedal inputs pass through a two-stage synchroniser before they are used. Gating is a clock enable on the system clock, so the interrupt output never carries a partial pulse.

Top module: `arpgate_top`

## Requirements
- R1: `clk_out` is a square wave with a period of PERIOD system-clock cycles. It is high for the first PERIOD/2 cycles of each period, counted from reset or from the latest restart, in every mode and start state.
- R2: A key press sets `start_o` only when `mode` is 2'b01 (arpeggio) or 2'b10 (split). With `mode` at 2'b00 or 2'b11, a key press leaves `start_o` low.
- R3: In the cycle where `start_o` rises, the oscillator phase restarts: `clk_out` is high in that cycle, and its next rising edge comes exactly PERIOD cycles later.
- R4: While `start_o` is high, `irq_clk` carries `clk_out` divided by two. `irq_clk` first rises PERIOD cycles after `start_o` rises, then stays high for PERIOD cycles and low for PERIOD cycles, and rises only together with a rising edge of `clk_out`.
- R5: `irq_clk` is low whenever `start_o` is low. When the synchronised key input goes low with both hold and pedal inactive, `start_o` and `irq_clk` drop at the next clock edge.
- R6: While `hold_sw` is 1 or `pedal_open` is 1 (synchronised), releasing the key does not clear `start_o`.
- R7: When `mode` is neither 2'b01 nor 2'b10, `start_o` is low after the next clock edge, whatever the key, hold and pedal inputs.
- R8: `key_down`, `hold_sw` and `pedal_open` pass through two flip-flops. A key press driven between edges shows on `start_o` at the third rising edge after it, and not earlier.
- R9: Synchronous active-high reset leaves `start_o` = 0, `irq_clk` = 0 and `clk_out` = 1, with the phase at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_down | input | 1 | Any key held, asynchronous |
| mode | input | 2 | Keyboard mode: 00 plain, 01 arpeggio, 10 split, 11 reserved |
| hold_sw | input | 1 | Hold switch on, asynchronous |
| pedal_open | input | 1 | Pedal circuit open (sustain), asynchronous |
| clk_out | output | 1 | Raw arpeggio square wave, always present |
| irq_clk | output | 1 | Halved arpeggio clock gated by start |
| start_o | output | 1 | Start latch state |

## Verification
The hardest state to reach is a held arpeggio. The key has already been released, hold or pedal is still keeping start set, and the phase counter is partway through a period when the clamp drops or the mode changes. Random stimulus keeps the key and the clamp inputs stable for long stretches and changes them with low probability, so releases land at every phase of the halved clock. Directed sequences press, clamp, release and then leave arpeggio mode on purpose. A cycle-level reference model counts the cycles since the last restart and compares all three outputs at every cycle.

// File: rtl/arpgate_pkg.sv
package arpgate_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_ARP   = 2'b01,
        MODE_SPLIT = 2'b10,
        MODE_RSVD  = 2'b11
    } kbd_mode_e;

    typedef struct packed {
        logic key;
        logic hold;
        logic pedal;
    } ctl_in_t;

    localparam int CTL_W = $bits(ctl_in_t);

    function automatic logic mode_runs_arp(kbd_mode_e m);
        return (m == MODE_ARP) || (m == MODE_SPLIT);
    endfunction

    function automatic logic clamp_active(ctl_in_t c);
        return c.hold | c.pedal;
    endfunction

endpackage

// File: rtl/arpgate_sync.sv
module arpgate_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/arpgate_osc.sv
module arpgate_osc #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic raw,
    output logic wrap
);
    localparam int HALF = PERIOD / 2;
    localparam int CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HALF_V = CW'(HALF);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || restart)     phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign raw  = (phase < HALF_V);
    assign wrap = (phase == LAST) && !restart;
endmodule

// File: rtl/arpgate_ctl.sv
module arpgate_ctl
    import arpgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  kbd_mode_e mode,
    input  ctl_in_t   ctl_s,
    input  logic      wrap,
    output logic      start,
    output logic      restart,
    output logic      half_clk
);
    logic arp_on;
    logic start_nx;

    assign arp_on  = mode_runs_arp(mode);
    assign restart = arp_on && ctl_s.key && !start;

    always_comb begin
        start_nx = start;
        if (!arp_on)                                start_nx = 1'b0;
        else if (ctl_s.key)                         start_nx = 1'b1;
        else if (!clamp_active(ctl_s))              start_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start    <= 1'b0;
            half_clk <= 1'b0;
        end else begin
            start <= start_nx;
            if (restart)   half_clk <= 1'b0;
            else if (wrap) half_clk <= ~half_clk;
        end
    end
endmodule

// File: rtl/arpgate_top.sv
module arpgate_top
    import arpgate_pkg::*;
#(
    parameter int PERIOD      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_down,
    input  logic [1:0] mode,
    input  logic       hold_sw,
    input  logic       pedal_open,
    output logic       clk_out,
    output logic       irq_clk,
    output logic       start_o
);
    ctl_in_t ctl_raw;
    ctl_in_t ctl_s;
    logic    restart;
    logic    wrap;
    logic    half_clk;
    logic    start;

    assign ctl_raw = '{key: key_down, hold: hold_sw, pedal: pedal_open};

    arpgate_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ctl_raw),
        .q_sync  (ctl_s)
    );

    arpgate_osc #(.PERIOD(PERIOD)) u_osc (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .raw     (clk_out),
        .wrap    (wrap)
    );

    arpgate_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode     (kbd_mode_e'(mode)),
        .ctl_s    (ctl_s),
        .wrap     (wrap),
        .start    (start),
        .restart  (restart),
        .half_clk (half_clk)
    );

    assign start_o = start;
    assign irq_clk = start & half_clk;
endmodule

// File: rtl/arpgate_chk.sv
module arpgate_chk
    import arpgate_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input ctl_in_t    ctl_s,
    input logic       clk_out,
    input logic       irq_clk,
    input logic       start_o
);
    logic arp_on;
    assign arp_on = mode_runs_arp(kbd_mode_e'(mode));

    // R5
    irq_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        irq_clk |-> start_o);

    // R2
    key_sets_start_chk: assert property (@(posedge clk) disable iff (rst)
        (arp_on && ctl_s.key) |=> start_o);

    // R7
    mode_exit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !arp_on |=> !start_o);

    // R6
    clamp_keeps_start_chk: assert property (@(posedge clk) disable iff (rst)
        (arp_on && start_o && (ctl_s.hold || ctl_s.pedal)) |=> start_o);

    // R3
    restart_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_o) |-> (clk_out && !irq_clk));

    // R4
    irq_on_raw_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_clk) |-> $rose(clk_out));
endmodule

bind arpgate_top arpgate_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .ctl_s   (ctl_s),
    .clk_out (clk_out),
    .irq_clk (irq_clk),
    .start_o (start_o)
);

// File: tb/sim_arpgate_top.sv
module sim_arpgate_top;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_down = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       hold_sw = 1'b0;
    logic       pedal_open = 1'b0;
    logic       clk_out, irq_clk, start_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    bit k1, k2, h1, h2, p1, p2;
    bit m_start;
    int m_phase;

    always #5 clk = ~clk;

    arpgate_top #(.PERIOD(P)) u0 (
        .clk(clk), .rst(rst), .key_down(key_down), .mode(mode),
        .hold_sw(hold_sw), .pedal_open(pedal_open),
        .clk_out(clk_out), .irq_clk(irq_clk), .start_o(start_o)
    );

    function automatic bit exp_raw(int ph);
        return (ph % P) < (P / 2);
    endfunction

    function automatic bit exp_irq(bit st, int ph);
        return st && (((ph / P) % 2) == 1);
    endfunction

    function automatic bit arp_mode(logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // model update at a rising edge, using inputs present before it
    always @(posedge clk) begin
        if (rst) begin
            {k1, k2, h1, h2, p1, p2} = '0;
            m_start = 0;
            m_phase = 0;
        end else begin
            bit nx;
            bit rs;
            rs = arp_mode(mode) && k2 && !m_start;
            if (!arp_mode(mode))  nx = 0;
            else if (k2)          nx = 1;
            else if (!(h2 || p2)) nx = 0;
            else                  nx = m_start;
            m_start = nx;
            m_phase = rs ? 0 : m_phase + 1;
            k2 = k1; k1 = key_down;
            h2 = h1; h1 = hold_sw;
            p2 = p1; p1 = pedal_open;
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " clk_out (R1)"}, clk_out, exp_raw(m_phase));
            check({tag, " start_o"}, start_o, m_start);
            check({tag, " irq_clk (R4)"}, irq_clk, exp_irq(m_start, m_phase));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 start", start_o, 1'b0);
        check("R9 irq", irq_clk, 1'b0);
        check("R9 clk_out", clk_out, 1'b1);
        rst = 1'b0;
        tag = "R1";
        step(2 * P + 3);

        // R2: key ignored in plain and reserved modes
        tag = "R2"; mode = 2'b00; key_down = 1'b1;
        step(10);
        check("R2 plain", start_o, 1'b0);
        mode = 2'b11;
        step(6);
        check("R2 reserved", start_o, 1'b0);
        key_down = 1'b0;
        step(4);

        // R8: synchroniser latency, R3/R4 first tick timing
        mode = 2'b01; tag = "R8";
        step(3);
        key_down = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R8 after two edges", start_o, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R8 third edge", start_o, 1'b1);
        check("R3 clk_out at restart", clk_out, 1'b1);
        step(P - 1);
        check("R4 before first tick", irq_clk, 1'b0);
        step(1);
        check("R4 first tick", irq_clk, 1'b1);
        tag = "R4";
        step(3 * P);

        // R5: release, no clamp
        tag = "R5"; key_down = 1'b0;
        step(4);
        check("R5 start cleared", start_o, 1'b0);
        check("R5 irq blocked", irq_clk, 1'b0);

        // R6: hold then pedal clamp
        tag = "R6"; mode = 2'b10; key_down = 1'b1;
        step(5);
        hold_sw = 1'b1; step(3); key_down = 1'b0;
        step(4 * P);
        check("R6 hold clamp", start_o, 1'b1);
        pedal_open = 1'b1; hold_sw = 1'b0;
        step(2 * P);
        check("R6 pedal clamp", start_o, 1'b1);
        pedal_open = 1'b0;
        step(4);
        check("R5 clamp dropped", start_o, 1'b0);

        // R7: leaving mode with key and clamp held
        tag = "R7"; mode = 2'b01; key_down = 1'b1; hold_sw = 1'b1;
        step(2 * P);
        mode = 2'b00;
        step(2);
        check("R7 mode exit", start_o, 1'b0);
        hold_sw = 1'b0; key_down = 1'b0;
        step(3);

        // random phase with fixed seed
        tag = "rand";
        void'($urandom(32'h5eed_a4b1));
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 4)       key_down = ~key_down;
            else if (r < 6)  hold_sw = ~hold_sw;
            else if (r < 8)  pedal_open = ~pedal_open;
            else if (r < 9)  mode = 2'($urandom % 4);
            else if (r < 12) mode = 2'b01;
            step(1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule